// File: doc/BRIEF.md
# Cascadable Vectored Priority Interrupt Controller

This block takes eight interrupt request lines and raises one interrupt line to an 8-bit CPU. When the CPU fetches its interrupt vector, the block answers with a three-byte jump: an opcode, then a page byte, then a low byte that encodes the winning request level. The CPU gives each bus access as a high address byte, captured when an address strobe falls, followed by a low byte offset. The high byte decides whether the access targets this unit's own registers or the shared vector space.

Several units can share one vector address. Each unit passes an enable along a daisy chain. A unit with a pending, unmasked request drops the enable to the units below it. Only the unit that sees the enable and also has work drives the bus during a vector fetch. Software sets the mask, the spacing between vectors, the low base and the page byte through four registers. Every unit decodes those registers at the same offsets.

Top module: `vpic_unit`

## Requirements
- R1: After reset the mask, control, base and page registers read 0, `int_out` is 0, `rdata_oe` is 0, and `cas_out` follows `cas_in`.
- R2: The high byte selects the unit when `(hi_addr ^ UNIT_PAT) & SEL_MASK` is zero. Once selected, a write at low offset 0 sets the mask, 1 sets the interval code in bits [1:0], 2 sets the vector low base and 3 sets the page. A read at the same offset returns the stored value with `rdata_oe` high. Bits of the high byte outside `SEL_MASK` are ignored.
- R3: The selection is captured only on the clock edge where `hi_stb` is seen falling, using `hi_addr` at that edge. Changing `hi_addr` later, with no new strobe, does not change which unit or space is selected.
- R4: A rising edge on `irq_in[i]` sets pending bit i. A level held high does not set the bit again after it has been cleared. `int_out` is high exactly when some pending bit is unmasked.
- R5: A mask bit set to 1 hides its pending request from `int_out`, from the cascade and from vector fetches. The request stays pending and appears once the mask bit is cleared.
- R6: Among unmasked pending requests, the highest index wins.
- R7: In vector space (high byte matching `VEC_PAT` under `SEL_MASK`), a responding unit returns `JUMP_OP` (default 8'hC0) at low offset 0, the page register at offset 1, and the low byte at offset 2. Offset 3 gets no response.
- R8: The low byte is `base | (level * spacing)`, where interval codes 0, 1, 2 and 3 give a spacing of 2, 4, 8 and 16 bytes.
- R9: A vector fetch at offset 2 clears the pending bit of the level it returned, so the next fetch presents the next-highest level.
- R10: `cas_out` is `cas_in` AND NOT any unmasked pending request. A unit drives `rdata_oe` for a vector fetch only when `cas_in` is high and it has an unmasked pending request.
- R11: Writes in vector space change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_stb | input | 1 | High-address strobe; selection captured on its falling edge |
| hi_addr | input | 8 | High address byte |
| lo_addr | input | 2 | Low address offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| irq_in | input | N_IRQ | Interrupt requests, bit N_IRQ-1 highest priority |
| cas_in | input | 1 | Cascade enable from the unit above (tie high at the top) |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | This unit drives the data bus |
| int_out | output | 1 | Interrupt request to the CPU |
| cas_out | output | 1 | Cascade enable to the unit below |

## Verification
A pending bit that is stuck or lost shows at once on `int_out` and `cas_out`. It also shows at the next offset-2 fetch as a wrong low byte, or as the wrong unit raising `rdata_oe`. A wrong interval decode or priority pick changes the low byte on the first fetch after the request is latched, which is one clock after its rising edge. A wrong selection capture shows on the next register read as data from the wrong unit. A clear that hits the wrong bit shows on the following fetch.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  // register offsets within a selected unit
  localparam logic [1:0] REG_MASK = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_BASE = 2'd2;
  localparam logic [1:0] REG_PAGE = 2'd3;

  // byte offsets within a vector fetch
  localparam logic [1:0] VB_OP   = 2'd0;
  localparam logic [1:0] VB_PAGE = 2'd1;
  localparam logic [1:0] VB_LOW  = 2'd2;

  // masked compare of a high address byte against a pattern
  function automatic logic addr_hit(input logic [7:0] addr,
                                    input logic [7:0] care,
                                    input logic [7:0] pat);
    return ((addr ^ pat) & care) == 8'd0;
  endfunction

  // low vector byte: base OR level shifted by (code + 1)
  function automatic logic [7:0] vec_low(input logic [7:0] base,
                                         input logic [7:0] lvl,
                                         input logic [1:0] code);
    logic [2:0] sh;
    sh = {1'b0, code} + 3'd1;
    return base | (lvl << sh);
  endfunction

endpackage

// File: rtl/vpic_addr_cap.sv
module vpic_addr_cap #(
  parameter logic [7:0] SEL_MASK = 8'hE3,
  parameter logic [7:0] UNIT_PAT = 8'hE1,
  parameter logic [7:0] VEC_PAT  = 8'hE0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_stb,
  input  logic [7:0] hi_addr,
  output logic       sel_unit,
  output logic       sel_vec,
  output logic       stb_fall
);
  import vpic_pkg::*;

  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= hi_stb;
  end

  assign stb_fall = stb_q & ~hi_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_unit <= 1'b0;
      sel_vec  <= 1'b0;
    end else if (stb_fall) begin
      sel_unit <= addr_hit(hi_addr, SEL_MASK, UNIT_PAT);
      sel_vec  <= addr_hit(hi_addr, SEL_MASK, VEC_PAT);
    end
  end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs #(
  parameter int DW     = 8,
  parameter int N      = 8,
  parameter int CODE_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  mask,
  output logic [CODE_W-1:0] icode,
  output logic [DW-1:0] vbase,
  output logic [DW-1:0] page,
  output logic [DW-1:0] rd_word
);
  import vpic_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '0;
      icode <= '0;
      vbase <= '0;
      page  <= '0;
    end else if (wr_stb) begin
      case (addr)
        REG_MASK: mask  <= wdata[N-1:0];
        REG_CTRL: icode <= wdata[CODE_W-1:0];
        REG_BASE: vbase <= wdata;
        default:  page  <= wdata;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      REG_MASK: rd_word[N-1:0]      = mask;
      REG_CTRL: rd_word[CODE_W-1:0] = icode;
      REG_BASE: rd_word             = vbase;
      default:  rd_word             = page;
    endcase
  end
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int N     = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic [N-1:0]     mask,
  input  logic             clr_pulse,
  input  logic [LVL_W-1:0] clr_lvl,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     pend_unm,
  output logic [N-1:0]     irq_rise,
  output logic             any_unm,
  output logic [LVL_W-1:0] top_lvl
);
  logic [N-1:0] irq_q;
  logic [N-1:0] clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  assign irq_rise = irq_in & ~irq_q;
  assign clr_vec  = clr_pulse ? (N'(1) << clr_lvl) : '0;

  // a new edge wins over a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | irq_rise;
  end

  assign pend_unm = pend & ~mask;
  assign any_unm  = |pend_unm;

  // highest index wins
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_unm[i]) top_lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/vpic_unit.sv
module vpic_unit #(
  parameter int         N_IRQ    = 8,
  parameter logic [7:0] SEL_MASK = 8'hE3,
  parameter logic [7:0] UNIT_PAT = 8'hE1,
  parameter logic [7:0] VEC_PAT  = 8'hE0,
  parameter logic [7:0] JUMP_OP  = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_stb,
  input  logic [7:0]       hi_addr,
  input  logic [1:0]       lo_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             cas_in,
  output logic [7:0]       rdata,
  output logic             rdata_oe,
  output logic             int_out,
  output logic             cas_out
);
  import vpic_pkg::*;

  localparam int LVL_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int CODE_W = 2;

  logic                sel_unit, sel_vec, stb_fall;
  logic [N_IRQ-1:0]    mask;
  logic [CODE_W-1:0]   icode;
  logic [7:0]          vbase, page, rd_word;
  logic [N_IRQ-1:0]    pend, pend_unm, irq_rise;
  logic                any_unm;
  logic [LVL_W-1:0]    top_lvl;
  logic                reg_wr, reg_rd, vec_resp, clr_pulse;
  logic [7:0]          vec_byte;

  vpic_addr_cap #(
    .SEL_MASK(SEL_MASK), .UNIT_PAT(UNIT_PAT), .VEC_PAT(VEC_PAT)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .hi_stb(hi_stb), .hi_addr(hi_addr),
    .sel_unit(sel_unit), .sel_vec(sel_vec), .stb_fall(stb_fall)
  );

  assign reg_wr = wr_en & sel_unit;
  assign reg_rd = rd_en & sel_unit;

  vpic_regs #(.DW(8), .N(N_IRQ), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(reg_wr), .addr(lo_addr),
    .wdata(wdata), .mask(mask), .icode(icode), .vbase(vbase),
    .page(page), .rd_word(rd_word)
  );

  vpic_prio #(.N(N_IRQ), .LVL_W(LVL_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
    .clr_pulse(clr_pulse), .clr_lvl(top_lvl), .pend(pend),
    .pend_unm(pend_unm), .irq_rise(irq_rise), .any_unm(any_unm),
    .top_lvl(top_lvl)
  );

  // vector fetch: only the enabled unit holding work answers
  assign vec_resp  = rd_en & sel_vec & cas_in & any_unm & (lo_addr != 2'd3);
  assign clr_pulse = vec_resp & (lo_addr == VB_LOW);

  always_comb begin
    case (lo_addr)
      VB_OP:   vec_byte = JUMP_OP;
      VB_PAGE: vec_byte = page;
      default: vec_byte = vec_low(vbase, 8'(top_lvl), icode);
    endcase
  end

  assign rdata_oe = reg_rd | vec_resp;
  assign rdata    = reg_rd ? rd_word : (vec_resp ? vec_byte : 8'd0);
  assign int_out  = any_unm;
  assign cas_out  = cas_in & ~any_unm;
endmodule

// File: rtl/vpic_unit_chk.sv
module vpic_unit_chk #(
  parameter int N     = 8,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb_fall,
  input logic             sel_unit,
  input logic             sel_vec,
  input logic             wr_en,
  input logic             cas_in,
  input logic             cas_out,
  input logic             int_out,
  input logic             vec_resp,
  input logic             clr_pulse,
  input logic [LVL_W-1:0] top_lvl,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     pend_unm,
  input logic [N-1:0]     irq_rise,
  input logic [N-1:0]     mask,
  input logic [1:0]       icode,
  input logic [7:0]       vbase,
  input logic [7:0]       page
);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> ($stable(sel_unit) && $stable(sel_vec)));

  // R10
  cas_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_in |-> !cas_out);

  // R10
  cas_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_out |-> !int_out);

  // R10
  resp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_resp |-> (cas_in && int_out));

  // R6
  prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_resp |-> ((pend_unm >> top_lvl) == N'(1)));

  // R9
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !irq_rise[top_lvl]) |=> !pend[$past(top_lvl)]);

  // R11
  vec_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_vec && !sel_unit) |=>
      ($stable(mask) && $stable(icode) && $stable(vbase) && $stable(page)));

  // R4
  int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |-> !int_out);
endmodule

bind vpic_unit vpic_unit_chk #(.N(N_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_fall(stb_fall), .sel_unit(sel_unit),
  .sel_vec(sel_vec), .wr_en(wr_en), .cas_in(cas_in), .cas_out(cas_out),
  .int_out(int_out), .vec_resp(vec_resp), .clr_pulse(clr_pulse),
  .top_lvl(top_lvl), .pend(pend), .pend_unm(pend_unm),
  .irq_rise(irq_rise), .mask(mask), .icode(icode), .vbase(vbase),
  .page(page)
);

// File: tb/vpic_unit_tb.sv
module vpic_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_stb = 1'b0;
  logic [7:0] hi_addr = 8'h00;
  logic [1:0] lo_addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] irq_a = 8'h00, irq_b = 8'h00;
  logic [7:0] rdata_a, rdata_b;
  logic       oe_a, oe_b, int_a, int_b, cas_ab, cas_b_out;
  logic [7:0] ra, rb;
  logic       oa, ob;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vpic_unit #(.UNIT_PAT(8'hE1)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_stb(hi_stb), .hi_addr(hi_addr),
    .lo_addr(lo_addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .irq_in(irq_a), .cas_in(1'b1), .rdata(rdata_a), .rdata_oe(oe_a),
    .int_out(int_a), .cas_out(cas_ab)
  );

  vpic_unit #(.UNIT_PAT(8'hE2)) u_low (
    .clk(clk), .rst_n(rst_n), .hi_stb(hi_stb), .hi_addr(hi_addr),
    .lo_addr(lo_addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .irq_in(irq_b), .cas_in(cas_ab), .rdata(rdata_b), .rdata_oe(oe_b),
    .int_out(int_b), .cas_out(cas_b_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic sel(input logic [7:0] h);
    @(negedge clk); hi_addr = h; hi_stb = 1'b1;
    @(negedge clk); hi_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk); lo_addr = o; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] o);
    @(negedge clk); lo_addr = o; rd_en = 1'b1;
    #1; ra = rdata_a; oa = oe_a; rb = rdata_b; ob = oe_b;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 int", {7'd0, int_a}, 8'd0);
    chk("R1 cas", {7'd0, cas_ab}, 8'd1);
    chk("R1 oe idle", {7'd0, oe_a}, 8'd0);
    sel(8'hE1);
    for (int o = 0; o < 4; o++) begin
      rd(2'(o));
      chk("R1 reg", ra, 8'h00);
      chk("R1 reg oe", {7'd0, oa}, 8'd1);
    end

    // R2 register access on both units, don't-care high bits
    wr(2'd2, 8'h80); wr(2'd3, 8'h3C);
    sel(8'hE2);
    wr(2'd1, 8'h02); wr(2'd2, 8'h01); wr(2'd3, 8'h5A);
    sel(8'hF5);
    rd(2'd3); chk("R2 page a", ra, 8'h3C); chk("R2 b quiet", {7'd0, ob}, 8'd0);
    rd(2'd2); chk("R2 base a", ra, 8'h80);
    sel(8'hE2);
    rd(2'd3); chk("R2 page b", rb, 8'h5A); chk("R2 a quiet", {7'd0, oa}, 8'd0);
    rd(2'd1); chk("R2 ctrl b", rb, 8'h02);

    // R11 writes in vector space ignored
    sel(8'hE0);
    wr(2'd3, 8'hFF); wr(2'd0, 8'hFF);
    sel(8'hE1);
    rd(2'd3); chk("R11 page", ra, 8'h3C);
    rd(2'd0); chk("R11 mask", ra, 8'h00);

    // R3 selection held after the strobe falls
    sel(8'hE1);
    @(negedge clk); hi_addr = 8'hE2;
    wr(2'd3, 8'h11);
    rd(2'd3); chk("R3 a page", ra, 8'h11); chk("R3 b quiet", {7'd0, ob}, 8'd0);
    sel(8'hE2);
    rd(2'd3); chk("R3 b page", rb, 8'h5A);
    sel(8'hE1); wr(2'd3, 8'h3C);

    // R7 R8 R9 R4: full sweep of interval code and level
    for (int s = 0; s < 4; s++) begin
      sel(8'hE1); wr(2'd1, 8'(s));
      for (int l = 0; l < 8; l++) begin
        @(negedge clk); irq_a[l] = 1'b1;
        @(negedge clk);
        chk("R4 int up", {7'd0, int_a}, 8'd1);
        sel(8'hE0);
        rd(2'd0); chk("R7 op", ra, 8'hC0); chk("R7 oe", {7'd0, oa}, 8'd1);
        rd(2'd1); chk("R7 page", ra, 8'h3C);
        rd(2'd2); chk("R8 low", ra, 8'h80 | 8'(l * (2 << s)));
        chk("R9 int cleared", {7'd0, int_a}, 8'd0);
        @(negedge clk);
        chk("R4 no relatch", {7'd0, int_a}, 8'd0);
        irq_a[l] = 1'b0;
      end
    end
    rd(2'd3); chk("R7 off3 quiet", {7'd0, oa}, 8'd0);

    // R5 mask hides then releases
    sel(8'hE1); wr(2'd1, 8'h01); wr(2'd0, 8'h08);
    @(negedge clk); irq_a[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 masked int", {7'd0, int_a}, 8'd0);
    chk("R5 masked cas", {7'd0, cas_ab}, 8'd1);
    sel(8'hE0); rd(2'd0); chk("R5 masked no resp", {7'd0, oa}, 8'd0);
    sel(8'hE1); wr(2'd0, 8'h00);
    chk("R5 unmasked int", {7'd0, int_a}, 8'd1);
    sel(8'hE0); rd(2'd2); chk("R5 level", ra, 8'h80 | 8'(3 * 4));
    irq_a[3] = 1'b0;

    // R6 priority order
    @(negedge clk); irq_a = 8'b0110_0100;
    @(negedge clk); irq_a = 8'h00;
    rd(2'd2); chk("R6 first", ra, 8'h80 | 8'(6 * 4));
    rd(2'd2); chk("R6 second", ra, 8'h80 | 8'(5 * 4));
    rd(2'd2); chk("R6 third", ra, 8'h80 | 8'(2 * 4));
    chk("R6 drained", {7'd0, int_a}, 8'd0);

    // R10 cascade
    @(negedge clk); irq_b[4] = 1'b1;
    @(negedge clk);
    chk("R10 cas open", {7'd0, cas_ab}, 8'd1);
    chk("R10 b int", {7'd0, int_b}, 8'd1);
    chk("R10 b blocks", {7'd0, cas_b_out}, 8'd0);
    rd(2'd1); chk("R10 a quiet", {7'd0, oa}, 8'd0); chk("R10 b page", rb, 8'h5A);
    rd(2'd2); chk("R10 b low", rb, 8'h01 | 8'(4 * 8));
    irq_b[4] = 1'b0;
    @(negedge clk); irq_a[1] = 1'b1; irq_b[7] = 1'b1;
    @(negedge clk);
    chk("R10 cas shut", {7'd0, cas_ab}, 8'd0);
    rd(2'd0); chk("R10 a answers", {7'd0, oa}, 8'd1); chk("R10 b held", {7'd0, ob}, 8'd0);
    rd(2'd2); chk("R10 a low", ra, 8'h80 | 8'(1 * 4));
    chk("R10 cas reopen", {7'd0, cas_ab}, 8'd1);
    rd(2'd2); chk("R10 b next", rb, 8'h01 | 8'(7 * 8)); chk("R10 b oe", {7'd0, ob}, 8'd1);
    irq_a[1] = 1'b0; irq_b[7] = 1'b0;
    sel(8'hE1); wr(2'd0, 8'h01);
    @(negedge clk); irq_a[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 masked keeps chain", {7'd0, cas_ab}, 8'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule